// File: doc/BRIEF.md
# Preamble Skip Filter for a Full-Speed Receiver

This block sits beside the packet decoder of a full-speed serial bus device that is not a hub. It watches the decoded packet identifiers and the line state on every clock. When the low-speed preamble identifier arrives, it holds a gate that keeps the downstream decoder blind. The gate stays closed through the idle pause that follows and through the whole low-speed packet. It reopens only after that low-speed packet's own terminating single-ended-zero (SE0) period.

The line state arrives as a two-bit code on each clock. The encoding is 2'b00 for SE0, 2'b01 for J, 2'b10 for K and 2'b11 for SE1. Full-speed K is the same level as low-speed J, so after the preamble the line first rests in K. The skip ends in three steps:

1. The filter waits for the first K.
2. It then waits for an SE0 run lasting `MIN_SE0` consecutive clocks.
3. Finally it waits for the line to return to J.

A watchdog of `TIMEOUT_CLKS` clocks releases the gate if the terminating SE0 never comes.

Top module: `usb_pre_skipper`

## Requirements
- R1: While reset is asserted and after its release, `rx_block` and `skip_busy` are both 0.
- R2: A `pid_valid` cycle with `pid_byte` = 8'h3C raises `rx_block` combinationally in that same cycle and raises `skip_busy` from the next clock. 8'h3C has low nibble 4'hC and high nibble equal to its complement.
- R3: Any other PID byte has no effect on either output. This includes a byte that fails the complement check, such as 8'h3D, a data PID such as 8'hC3, and 8'h2C.
- R4: After the preamble, SE0 of any length seen before the first K (line code 2'b10) is ignored, and the skip continues.
- R5: Once K has been seen, an SE0 (line code 2'b00) run shorter than `MIN_SE0` consecutive clocks does not end the skip.
- R6: An SE0 run of exactly `MIN_SE0` consecutive clocks after the K marks the packet end. The outputs then stay high until the line shows J (code 2'b01). They drop at the clock after the first J cycle, and K or SE0 in between does not release them.
- R7: While the skip is active, further PID bytes, including another preamble, are ignored. The release still occurs at the clock fixed by R6.
- R8: If the skip has been active for `TIMEOUT_CLKS` clocks without releasing, both outputs drop, and a later preamble starts a new skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pid_valid | input | 1 | `pid_byte` holds a decoded identifier this cycle |
| pid_byte | input | 8 | Decoded packet identifier byte |
| line_state | input | 2 | Line code: 00 SE0, 01 J, 10 K, 11 SE1 |
| rx_block | output | 1 | Gate to the packet decoder; 1 means discard |
| skip_busy | output | 1 | Registered flag, a skip is in progress |

## Verification
The hardest case to reach is the exact boundary of the terminating SE0. The run must be one clock short in one instance and exactly `MIN_SE0` in another. Both must come after the K pause, and stray SE0 and PID bytes appear earlier in the same skip. The bench drives one continuous line-state sequence for this. It starts with a long SE0 before any K. Then come the K pause and J/K activity with a three-clock SE0. After that, injected PIDs and a four-clock SE0 follow, then K before the final J. The outputs are checked after every phase. A second sequence holds the line in J/K without any SE0 to run the watchdog to its exact expiry clock.

// File: rtl/usb_pre_pkg.sv
package usb_pre_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_SEEN,
    ST_WAIT_SE0,
    ST_DONE
  } skip_state_e;

  localparam logic [3:0] PREAMBLE_CODE = 4'hC;

  // Preamble: low nibble is the code, high nibble must be its complement.
  function automatic logic pid_is_preamble(input logic [7:0] pid);
    return (pid[3:0] == PREAMBLE_CODE) && (pid[7:4] == ~pid[3:0]);
  endfunction

endpackage

// File: rtl/pre_pid_match.sv
module pre_pid_match (
  input  logic       pid_valid,
  input  logic [7:0] pid_byte,
  output logic       is_pre
);
  import usb_pre_pkg::*;

  always_comb is_pre = pid_valid && pid_is_preamble(pid_byte);
endmodule

// File: rtl/se0_run_filter.sv
module se0_run_filter #(
  parameter int MIN_SE0 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  output logic       se0_qual
);
  import usb_pre_pkg::*;

  localparam int CW = (MIN_SE0 < 2) ? 1 : $clog2(MIN_SE0);
  localparam logic [CW-1:0] LAST = CW'(MIN_SE0 - 1);

  logic [CW-1:0] run_cnt;
  logic          is_se0;

  always_comb begin
    is_se0   = (line_state == LN_SE0);
    se0_qual = is_se0 && (run_cnt >= LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= '0;
    else if (!is_se0)               run_cnt <= '0;
    else if (run_cnt < LAST)        run_cnt <= run_cnt + 1'b1;
  end
endmodule

// File: rtl/skip_timer.sv
module skip_timer #(
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = (TIMEOUT_CLKS < 2) ? 1 : $clog2(TIMEOUT_CLKS);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CLKS - 1);

  logic [TW-1:0] cnt;

  always_comb expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usb_pre_skipper.sv
module usb_pre_skipper #(
  parameter int MIN_SE0      = 4,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pid_valid,
  input  logic [7:0] pid_byte,
  input  logic [1:0] line_state,
  output logic       rx_block,
  output logic       skip_busy
);
  import usb_pre_pkg::*;

  skip_state_e state, state_nx;
  logic        is_pre;
  logic        pre_hit;
  logic        se0_qual;
  logic        timeout_hit;
  logic        timer_run;

  pre_pid_match u_match (
    .pid_valid (pid_valid),
    .pid_byte  (pid_byte),
    .is_pre    (is_pre)
  );

  se0_run_filter #(.MIN_SE0(MIN_SE0)) u_se0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_state (line_state),
    .se0_qual   (se0_qual)
  );

  skip_timer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .expire (timeout_hit)
  );

  always_comb begin
    timer_run = (state != ST_IDLE);
    pre_hit   = is_pre && (state == ST_IDLE);
  end

  always_comb begin
    state_nx = state;
    if (timeout_hit) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:     if (pre_hit) state_nx = ST_PRE_SEEN;
        ST_PRE_SEEN: if (line_state == LN_K) state_nx = ST_WAIT_SE0;
        ST_WAIT_SE0: if (se0_qual) state_nx = ST_DONE;
        ST_DONE:     if (line_state == LN_J) state_nx = ST_IDLE;
        default:     state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    skip_busy = (state != ST_IDLE);
    rx_block  = skip_busy || pre_hit;
  end
endmodule

// File: rtl/usb_pre_skipper_chk.sv
module usb_pre_skipper_chk (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                line_state,
  input logic                      rx_block,
  input logic                      skip_busy,
  input logic                      pre_hit,
  input logic                      se0_qual,
  input logic                      timeout_hit,
  input usb_pre_pkg::skip_state_e  state
);
  import usb_pre_pkg::*;

  // R2
  busy_starts_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_busy) |-> $past(pre_hit));

  // R2
  gate_covers_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_busy |-> rx_block);

  // R4
  pre_seen_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRE_SEEN && line_state != LN_K && !timeout_hit) |=> (state == ST_PRE_SEEN));

  // R6
  done_needs_long_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state) == ST_WAIT_SE0) |-> $past(se0_qual));

  // R6
  done_releases_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && line_state == LN_J) |=> !skip_busy);

  // R8
  timeout_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> !skip_busy);
endmodule

bind usb_pre_skipper usb_pre_skipper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_state  (line_state),
  .rx_block    (rx_block),
  .skip_busy   (skip_busy),
  .pre_hit     (pre_hit),
  .se0_qual    (se0_qual),
  .timeout_hit (timeout_hit),
  .state       (state)
);

// File: tb/usb_pre_skipper_test.sv
module usb_pre_skipper_test;
  localparam int MIN_SE0 = 4;
  localparam int TO_CLKS = 60;
  localparam logic [1:0] SE0 = 2'b00, JJ = 2'b01, KK = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pid_valid = 1'b0;
  logic [7:0] pid_byte = 8'h00;
  logic [1:0] line_state = JJ;
  logic       rx_block, skip_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  usb_pre_skipper #(.MIN_SE0(MIN_SE0), .TIMEOUT_CLKS(TO_CLKS)) uut (
    .clk(clk), .rst_n(rst_n), .pid_valid(pid_valid), .pid_byte(pid_byte),
    .line_state(line_state), .rx_block(rx_block), .skip_busy(skip_busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Hold line state for n clocks with no PID.
  task automatic hold(input logic [1:0] ls, input int n);
    pid_valid = 1'b0; line_state = ls;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_pre();
    line_state = KK; pid_valid = 1'b1; pid_byte = 8'h3C; #1;
    chk("R2 gate same cycle", rx_block, 1'b1);
    tick();
    pid_valid = 1'b0;
    chk("R2 busy next clock", skip_busy, 1'b1);
  endtask

  task automatic t_reset();
    hold(JJ, 2);
    chk("R1 gate in reset", rx_block, 1'b0);
    chk("R1 busy in reset", skip_busy, 1'b0);
    rst_n = 1'b1;
    hold(JJ, 2);
    chk("R1 gate after reset", rx_block, 1'b0);
    chk("R1 busy after reset", skip_busy, 1'b0);
  endtask

  task automatic t_non_pre();
    logic [7:0] ids [3] = '{8'h3D, 8'hC3, 8'h2C};
    foreach (ids[i]) begin
      line_state = JJ; pid_valid = 1'b1; pid_byte = ids[i]; #1;
      chk("R3 gate other pid", rx_block, 1'b0);
      tick();
      pid_valid = 1'b0;
      chk("R3 busy other pid", skip_busy, 1'b0);
    end
  endtask

  task automatic t_full_skip();
    hold(JJ, 1);
    send_pre();
    hold(SE0, 6);
    chk("R4 se0 before K ignored", skip_busy, 1'b1);
    hold(JJ, 2);
    chk("R4 still busy", skip_busy, 1'b1);
    hold(KK, 3);
    hold(JJ, 1); hold(KK, 1); hold(JJ, 1);
    hold(SE0, MIN_SE0 - 1);
    hold(JJ, 1);
    chk("R5 short se0 ignored", skip_busy, 1'b1);
    hold(KK, 1);
    // R7: PIDs during skip, including another preamble
    line_state = JJ; pid_valid = 1'b1; pid_byte = 8'h3C; tick();
    pid_byte = 8'hC3; tick();
    pid_valid = 1'b0;
    chk("R7 pids ignored", skip_busy, 1'b1);
    hold(SE0, MIN_SE0);
    chk("R6 busy held after end se0", skip_busy, 1'b1);
    chk("R6 gate held after end se0", rx_block, 1'b1);
    hold(SE0, 1);
    hold(KK, 1);
    chk("R6 K does not release", skip_busy, 1'b1);
    hold(JJ, 1);
    chk("R6 J releases busy", skip_busy, 1'b0);
    chk("R6 J releases gate", rx_block, 1'b0);
    hold(JJ, 2);
    chk("R7 no retrigger", skip_busy, 1'b0);
  endtask

  task automatic t_timeout();
    hold(JJ, 1);
    send_pre();
    for (int i = 0; i < TO_CLKS - 1; i++) hold((i % 2 == 0) ? KK : JJ, 1);
    chk("R8 busy before expiry", skip_busy, 1'b1);
    hold(JJ, 1);
    chk("R8 released at expiry", skip_busy, 1'b0);
    chk("R8 gate released", rx_block, 1'b0);
    send_pre();
    hold(KK, 1);
    chk("R8 rearmed after timeout", skip_busy, 1'b1);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_non_pre();
    t_full_skip();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule